// File: doc/BRIEF.md
# Multichannel Synchronous Serial Port

This block is a synchronous serial transmit and receive port that sits beside a signal-processing core. A serial bit strobe (`bit_en`) marks the ticks of the serial clock in the system clock domain. A one-tick frame sync starts a frame, and data moves MSB first on the ticks that follow. Received words are right-justified into a 16-bit register that the core reads. Transmit words are taken from a holding register that the core writes. The word length can be set from 3 to 16 bits.

Inline G.711 companding can be turned on for either mu-law or A-law. Received 8-bit codes then reach the core as 16-bit linear values, and 16-bit linear transmit values leave as 8-bit codes. In multichannel mode a frame carries 24 or 32 consecutive slots. Two 32-bit masks, one per direction, pick which slots are received and which are driven. Each direction has its own completion interrupt.

An optional circular-buffer address counter per direction steps by a stride on every transferred word and returns to the base address at the end of the buffer. While it is on, the interrupt fires only at that wrap.

Top module: `mcsp_port`

## Requirements
- R1: The word length is `word_len`+1 bits, for lengths 3 to 16; `word_len` values 0 and 1 act as 2 (3 bits). Bits move MSB first. A received word appears right-justified in `rx_rdata` with all bits above the word length at zero. The transmitted bits are the low (`word_len`+1) bits of the written value.
- R2: A frame sync seen on a bit tick starts a frame, and the first data bit is on the following bit tick. With `mc_en`=0 a frame holds exactly one word. `sdata_oe` is low before the frame starts and after it ends.
- R3: When a receive word completes in an enabled slot, `rx_rdata` and `rx_full`=1 update and `rx_irq` is high for exactly the one cycle after the tick of the last bit. A pulse on `rx_rd` clears `rx_full`.
- R4: If a word completes while `rx_full`=1 and there is no read in the same cycle, `rx_ovf` becomes 1 and `rx_rdata` takes the newer word. `rx_rd` clears both flags.
- R5: The transmit word for a slot is taken from the holding register (written by `tx_wr`) when the slot starts. `sdata_oe`=1 only during enabled transmit slots, and `sdata_o` is 0 whenever `sdata_oe`=0. `tx_irq` pulses in the cycle after the last bit of each transmitted word.
- R6: With `mc_en`=1, a frame has 24 slots (`mc_32`=0) or 32 slots (`mc_32`=1). Bit n of `rx_mask` or `tx_mask` enables slot n. A disabled receive slot raises no `rx_irq` and leaves `rx_full` untouched, and a disabled transmit slot keeps `sdata_oe` low and raises no `tx_irq`.
- R7: With `comp_sel`=2'b10, mu-law is used. The word length becomes 8, and a received code c gives the linear value s*(((m<<3)+132)<<e)-132 taken with sign, where u=~c, s=u[7], e=u[6:4], m=u[3:0]. Transmit values are clipped to magnitude 32635, biased by 132 and coded in the same format.
- R8: With `comp_sel`=2'b11, A-law is used. The word length becomes 8, and a code c is XORed with 0x55; bit 7 set means positive. The segment is bits 6:4 and the mantissa is bits 3:0. Segment 0 decodes to m*16+8, and segment k>0 decodes to (m*16+264)<<(k-1). Transmit values are the linear value shifted right by 3 and coded in the same format.
- R9: While `ab_en`=0, each address counter holds `ab_base`. While `ab_en`=1, each word transferred in that direction adds `ab_stride`. A sum at or above `ab_base`+`ab_len` returns the counter to `ab_base`.
- R10: While `ab_en`=1, `rx_irq` and `tx_irq` pulse only for the word that wraps their direction's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Serial bit tick strobe |
| fsync_i | input | 1 | Frame sync, one tick wide |
| sdata_i | input | 1 | Serial receive data |
| sdata_o | output | 1 | Serial transmit data |
| sdata_oe | output | 1 | Transmit drive enable |
| word_len | input | 4 | Word length minus one |
| comp_sel | input | 2 | 0x: linear, 10: mu-law, 11: A-law |
| mc_en | input | 1 | Multichannel mode enable |
| mc_32 | input | 1 | 32-slot frame when set, else 24 |
| rx_mask | input | 32 | Receive slot enables |
| tx_mask | input | 32 | Transmit slot enables |
| tx_wr | input | 1 | Write strobe for transmit holding register |
| tx_wdata | input | 16 | Transmit word |
| rx_rd | input | 1 | Read acknowledge for received word |
| rx_rdata | output | 16 | Received word, right-justified |
| rx_full | output | 1 | Received word waiting |
| rx_ovf | output | 1 | Received word overwritten before read |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| ab_en | input | 1 | Circular-buffer addressing enable |
| ab_base | input | AW | Buffer base address |
| ab_len | input | AW | Buffer length |
| ab_stride | input | AW | Address step per word |
| rx_ab_addr | output | AW | Receive buffer address |
| tx_ab_addr | output | AW | Transmit buffer address |

## Verification
The hardest situation to reach is the final slot of a 32-slot frame with alternating per-direction masks. There, a receive read, a transmit write for the next slot and the slot boundary all fall within two ticks of each other. The bench runs whole 24- and 32-slot frames whose masks reach slot 31, reads each word on the tick after it completes, and writes the next transmit word one tick into the current slot. The companders are swept over all 256 codes and over 256 linear values spread from full negative to full positive scale, in both laws.

// File: rtl/mcsp_pkg.sv
// Shared widths, mode codes and G.711 conversion functions for the serial port.
// Assumes 16-bit linear samples and 8-bit companded codes.
package mcsp_pkg;
    localparam int WORD_W          = 16;
    localparam int LEN_W           = $clog2(WORD_W);
    localparam int CODE_W          = 8;
    localparam int MC_SLOTS_SHORT  = 24;
    localparam int MC_SLOTS_LONG   = 32;
    localparam int SLOT_W          = $clog2(MC_SLOTS_LONG);
    localparam logic [1:0] CMP_MU  = 2'b10;
    localparam logic [1:0] CMP_A   = 2'b11;

    // Linear to mu-law: clip, bias, find segment, keep four mantissa bits, invert.
    function automatic logic [CODE_W-1:0] mu_compress(input logic [WORD_W-1:0] x);
        logic              neg;
        logic [WORD_W-1:0] mag;
        logic [WORD_W-1:0] sh;
        logic [2:0]        ex;
        neg = x[WORD_W-1];
        mag = neg ? (~x + 16'd1) : x;
        if (mag > 16'd32635) mag = 16'd32635;
        mag = mag + 16'd132;
        ex  = 3'd0;
        for (int k = 1; k < 8; k++) if (mag[k+7]) ex = 3'(k);
        sh = mag >> ({1'b0, ex} + 4'd3);
        return ~{neg, ex, sh[3:0]};
    endfunction

    // Mu-law to linear.
    function automatic logic [WORD_W-1:0] mu_expand(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] u;
        logic [WORD_W-1:0] t;
        u = ~c;
        t = ({12'd0, u[3:0]} << 3) + 16'd132;
        t = t << u[6:4];
        return u[7] ? (16'd132 - t) : (t - 16'd132);
    endfunction

    // Linear to A-law: drop three bits, fold sign, count segment, mask alternate bits.
    function automatic logic [CODE_W-1:0] a_compress(input logic [WORD_W-1:0] x);
        logic signed [WORD_W-1:0] p;
        logic [11:0]              pm;
        logic [11:0]              sh;
        logic [2:0]               seg;
        logic [CODE_W-1:0]        msk;
        p   = $signed(x) >>> 3;
        msk = 8'hD5;
        if (p < 0) begin
            msk = 8'h55;
            p   = -p - 16'sd1;
        end
        pm  = p[11:0];
        seg = 3'd0;
        for (int k = 0; k < 7; k++) if (pm >= (12'd32 << k)) seg = seg + 3'd1;
        sh = (seg < 3'd2) ? (pm >> 1) : (pm >> seg);
        return {1'b0, seg, sh[3:0]} ^ msk;
    endfunction

    // A-law to linear.
    function automatic logic [WORD_W-1:0] a_expand(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] a;
        logic [WORD_W-1:0] t;
        a = c ^ 8'h55;
        t = {8'd0, a[3:0], 4'd0};
        if (a[6:4] == 3'd0) t = t + 16'd8;
        else                t = (t + 16'h108) << (a[6:4] - 3'd1);
        return a[7] ? t : (~t + 16'd1);
    endfunction
endpackage

// File: rtl/mcsp_frame.sv
// Frame and slot sequencer shared by both directions.
// Assumes length and mode inputs stay still while a frame is in progress.
module mcsp_frame
    import mcsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic [LEN_W-1:0]  wlen_m1,
    input  logic              mc_en,
    input  logic              mc_32,
    output logic              active,
    output logic [LEN_W-1:0]  bit_cnt,
    output logic [SLOT_W-1:0] slot,
    output logic              word_end,
    output logic              word_start,
    output logic [SLOT_W-1:0] nslot
);
    localparam logic [SLOT_W-1:0] LAST_SHORT = SLOT_W'(MC_SLOTS_SHORT - 1);
    localparam logic [SLOT_W-1:0] LAST_LONG  = SLOT_W'(MC_SLOTS_LONG - 1);

    logic last_slot;

    // Decode slot boundaries and the slot that comes next.
    always_comb begin
        last_slot  = !mc_en || (slot == (mc_32 ? LAST_LONG : LAST_SHORT));
        word_end   = bit_en && active && !fsync && (bit_cnt == wlen_m1);
        word_start = bit_en && (fsync || (word_end && !last_slot));
        nslot      = fsync ? '0 : slot + 1'b1;
    end

    // Advance bit and slot counters on each serial tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_cnt <= '0;
            slot    <= '0;
        end else if (bit_en) begin
            if (fsync) begin
                active  <= 1'b1;
                bit_cnt <= '0;
                slot    <= '0;
            end else if (active) begin
                if (bit_cnt == wlen_m1) begin
                    bit_cnt <= '0;
                    if (last_slot) active <= 1'b0;
                    else           slot   <= slot + 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    a_r1_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> bit_cnt <= wlen_m1);
    a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mc_en) |-> slot == '0);
    a_r2_word_gap: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> !word_end);
    a_r6_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mc_en && !mc_32) |-> slot <= LAST_SHORT);
endmodule

// File: rtl/mcsp_abuf.sv
// Circular-buffer address counter for one direction.
// Assumes base, length and stride stay still while enabled and length is non-zero.
module mcsp_abuf #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] addr,
    output logic          wrap
);
    logic [AW:0] nxt;
    logic [AW:0] lim;

    // Next address and the end-of-buffer test.
    always_comb begin
        nxt  = {1'b0, addr} + {1'b0, stride};
        lim  = {1'b0, base} + {1'b0, len};
        wrap = en && step && (nxt >= lim);
    end

    // Hold base while idle; step or wrap on each word.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) addr <= base;
        else if (step)     addr <= wrap ? base : nxt[AW-1:0];
    end

    a_r9_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        (en && len != '0) |-> (addr >= base) && ({1'b0, addr} < lim));
    a_r10_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && en) |=> addr == $past(base));
endmodule

// File: rtl/mcsp_port.sv
// Multichannel synchronous serial port: framed serial receive and transmit with
// programmable length, optional G.711 companding, slot masks and circular-buffer
// addressing. Assumes configuration inputs change only between frames.
module mcsp_port
    import mcsp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_en,
    input  logic                     fsync_i,
    input  logic                     sdata_i,
    output logic                     sdata_o,
    output logic                     sdata_oe,
    input  logic [LEN_W-1:0]         word_len,
    input  logic [1:0]               comp_sel,
    input  logic                     mc_en,
    input  logic                     mc_32,
    input  logic [MC_SLOTS_LONG-1:0] rx_mask,
    input  logic [MC_SLOTS_LONG-1:0] tx_mask,
    input  logic                     tx_wr,
    input  logic [WORD_W-1:0]        tx_wdata,
    input  logic                     rx_rd,
    output logic [WORD_W-1:0]        rx_rdata,
    output logic                     rx_full,
    output logic                     rx_ovf,
    output logic                     rx_irq,
    output logic                     tx_irq,
    input  logic                     ab_en,
    input  logic [AW-1:0]            ab_base,
    input  logic [AW-1:0]            ab_len,
    input  logic [AW-1:0]            ab_stride,
    output logic [AW-1:0]            rx_ab_addr,
    output logic [AW-1:0]            tx_ab_addr
);
    localparam int DIRS = 2;

    logic              comp_on;
    logic [LEN_W-1:0]  wlen_m1;
    logic              active;
    logic [LEN_W-1:0]  bit_cnt;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] nslot;
    logic              word_end;
    logic              word_start;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] rx_shift_in;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] tx_hold;
    logic [WORD_W-1:0] tx_cur;
    logic [WORD_W-1:0] tx_load;
    logic              tx_live;
    logic              rx_done;
    logic              tx_done;
    logic              tx_next_on;
    logic [DIRS-1:0]   dir_step;
    logic [DIRS-1:0]   dir_wrap;
    logic [AW-1:0]     dir_addr [DIRS];

    // Effective word length: forced to 8 when companding, floored at 3.
    always_comb begin
        comp_on = comp_sel[1];
        if (comp_on)                    wlen_m1 = LEN_W'(CODE_W - 1);
        else if (word_len < LEN_W'(2))  wlen_m1 = LEN_W'(2);
        else                            wlen_m1 = word_len;
    end

    mcsp_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .fsync      (fsync_i),
        .wlen_m1    (wlen_m1),
        .mc_en      (mc_en),
        .mc_32      (mc_32),
        .active     (active),
        .bit_cnt    (bit_cnt),
        .slot       (slot),
        .word_end   (word_end),
        .word_start (word_start),
        .nslot      (nslot)
    );

    // Receive word assembly, justification and expansion.
    always_comb begin
        rx_shift_in = {rx_sh[WORD_W-2:0], sdata_i};
        rx_done     = word_end && (!mc_en || rx_mask[slot]);
        if (comp_sel == CMP_MU)     rx_word = mu_expand(rx_shift_in[CODE_W-1:0]);
        else if (comp_sel == CMP_A) rx_word = a_expand(rx_shift_in[CODE_W-1:0]);
        else rx_word = rx_shift_in & ({WORD_W{1'b1}} >> (LEN_W'(WORD_W - 1) - wlen_m1));
    end

    // Transmit word selection, compression and bit output.
    always_comb begin
        tx_next_on = !mc_en || tx_mask[nslot];
        tx_done    = word_end && tx_live;
        if (comp_sel == CMP_MU)     tx_load = {8'd0, mu_compress(tx_hold)};
        else if (comp_sel == CMP_A) tx_load = {8'd0, a_compress(tx_hold)};
        else                        tx_load = tx_hold;
        sdata_oe = active && tx_live;
        sdata_o  = sdata_oe && tx_cur[wlen_m1 - bit_cnt];
    end

    // Receive register, full/overflow flags and receive interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            rx_rdata <= '0;
            rx_full  <= 1'b0;
            rx_ovf   <= 1'b0;
            rx_irq   <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (bit_en && active && !fsync_i) rx_sh <= rx_shift_in;
            if (rx_rd) begin
                rx_full <= 1'b0;
                rx_ovf  <= 1'b0;
            end
            if (rx_done) begin
                rx_rdata <= rx_word;
                rx_full  <= 1'b1;
                if (rx_full && !rx_rd) rx_ovf <= 1'b1;
                rx_irq   <= ab_en ? dir_wrap[0] : 1'b1;
            end
        end
    end

    // Transmit holding register, slot load and transmit interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_cur  <= '0;
            tx_live <= 1'b0;
            tx_irq  <= 1'b0;
        end else begin
            if (tx_wr) tx_hold <= tx_wdata;
            if (word_start) begin
                tx_live <= tx_next_on;
                if (tx_next_on) tx_cur <= tx_load;
            end
            tx_irq <= tx_done && (ab_en ? dir_wrap[1] : 1'b1);
        end
    end

    assign dir_step = {tx_done, rx_done};

    generate
        for (genvar d = 0; d < DIRS; d++) begin : g_abuf
            mcsp_abuf #(.AW(AW)) u_abuf (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (ab_en),
                .step   (dir_step[d]),
                .base   (ab_base),
                .len    (ab_len),
                .stride (ab_stride),
                .addr   (dir_addr[d]),
                .wrap   (dir_wrap[d])
            );
        end
    endgenerate

    assign rx_ab_addr = dir_addr[0];
    assign tx_ab_addr = dir_addr[1];

    a_r4_ovf_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |-> rx_full);
    a_r3_full_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> rx_full);
    a_r3_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sdata_oe && !sdata_o);
endmodule

// File: tb/mcsp_port_tb_top.sv
`timescale 1ns/1ps
module mcsp_port_tb_top;
    import mcsp_pkg::*;

    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b1;
    logic fsync_i = 1'b0;
    logic sdata_i = 1'b0;
    logic sdata_o, sdata_oe;
    logic [3:0] word_len = 4'd7;
    logic [1:0] comp_sel = 2'b00;
    logic mc_en = 1'b0, mc_32 = 1'b0;
    logic [31:0] rx_mask = '0, tx_mask = '0;
    logic tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic rx_full, rx_ovf, rx_irq, tx_irq;
    logic ab_en = 1'b0;
    logic [AW-1:0] ab_base = '0, ab_len = '0, ab_stride = '0;
    logic [AW-1:0] rx_ab_addr, tx_ab_addr;

    int errors = 0;
    int checks = 0;
    logic [15:0] txcap;
    int oe_low;
    logic [15:0] rxv [33];
    logic [15:0] txv [33];

    always #4 clk = ~clk;

    mcsp_port #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync_i(fsync_i),
        .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
        .word_len(word_len), .comp_sel(comp_sel), .mc_en(mc_en), .mc_32(mc_32),
        .rx_mask(rx_mask), .tx_mask(tx_mask), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .rx_rd(rx_rd), .rx_rdata(rx_rdata), .rx_full(rx_full), .rx_ovf(rx_ovf),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .ab_en(ab_en), .ab_base(ab_base),
        .ab_len(ab_len), .ab_stride(ab_stride), .rx_ab_addr(rx_ab_addr),
        .tx_ab_addr(tx_ab_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench-side G.711 arithmetic
    function automatic int b_mu_dec(input int c);
        int u, e, m, mag;
        u = (~c) & 255; e = (u >> 4) & 7; m = u & 15;
        mag = 4 * (((2 * m + 33) << e) - 33);
        return (u & 128) != 0 ? -mag : mag;
    endfunction
    function automatic int b_mu_enc(input int x);
        int s, v, e, m;
        s = (x < 0) ? 1 : 0; v = s ? -x : x;
        if (v > 32635) v = 32635;
        v = v + 132; e = 0;
        while (e < 7 && v >= (256 << e)) e++;
        m = (v >> (e + 3)) & 15;
        return (~((s << 7) | (e << 4) | m)) & 255;
    endfunction
    function automatic int b_a_dec(input int c);
        int a, m, seg, mag;
        a = c ^ 85; m = a & 15; seg = (a >> 4) & 7;
        mag = (seg == 0) ? (m * 16 + 8) : ((m * 16 + 264) << (seg - 1));
        return (a & 128) != 0 ? mag : -mag;
    endfunction
    function automatic int b_a_enc(input int x);
        int p, mk, seg, av;
        p = x >>> 3; mk = 213;
        if (p < 0) begin mk = 85; p = -p - 1; end
        seg = 0;
        while (seg < 8 && p > ((32 << seg) - 1)) seg++;
        av = (seg << 4) | (((seg < 2) ? (p >> 1) : (p >> seg)) & 15);
        return (av ^ mk) & 255;
    endfunction

    task automatic write_tx(input logic [15:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask
    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // One single-word frame; ends at the negedge right after the last bit's tick.
    task automatic one_word(input int len, input logic [15:0] v);
        @(negedge clk); fsync_i = 1'b1;
        @(negedge clk); fsync_i = 1'b0;
        txcap = '0; oe_low = 0;
        for (int i = len - 1; i >= 0; i--) begin
            sdata_i = v[i];
            txcap = {txcap[14:0], sdata_o};
            if (!sdata_oe) oe_low++;
            @(negedge clk);
        end
        sdata_i = 1'b0;
    endtask

    // One multichannel frame; rxv/txv hold per-slot data.
    task automatic mc_frame(input int nslots, input int len);
        logic [15:0] m, cap;
        int bad;
        m = 16'((32'd1 << len) - 1);
        write_tx(txv[0]);
        @(negedge clk); fsync_i = 1'b1;
        @(negedge clk); fsync_i = 1'b0;
        for (int s = 0; s < nslots; s++) begin
            cap = '0; bad = 0;
            for (int b = 0; b < len; b++) begin
                if (b == 1) begin rx_rd = 1'b0; tx_wr = 1'b1; tx_wdata = txv[s + 1]; end
                else tx_wr = 1'b0;
                sdata_i = rxv[s][len - 1 - b];
                if (sdata_oe != tx_mask[s]) bad++;
                cap = {cap[14:0], sdata_o};
                @(negedge clk);
            end
            chk(bad == 0, "R6 slot drive enable", bad, 0);
            chk(rx_irq == rx_mask[s], "R6 rx slot select", int'(rx_irq), int'(rx_mask[s]));
            chk(tx_irq == tx_mask[s], "R6 tx slot select", int'(tx_irq), int'(tx_mask[s]));
            if (rx_mask[s]) chk(rx_rdata == (rxv[s] & m), "R6 rx slot data", rx_rdata, rxv[s] & m);
            else            chk(!rx_full, "R6 disabled slot ignored", int'(rx_full), 0);
            if (tx_mask[s]) chk(cap == (txv[s] & m), "R6 tx slot data", cap, txv[s] & m);
            else            chk(cap == 0, "R5 idle line in off slot", cap, 0);
            rx_rd = 1'b1;
        end
        tx_wr = 1'b0;
        sdata_i = 1'b0;
        @(negedge clk); rx_rd = 1'b0;
        chk(!sdata_oe && !rx_irq, "R2 frame ended", int'(sdata_oe), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] pats [3];
        int idx, nxt, wrapped, exp;
        pats[0] = 16'hFFFF; pats[1] = 16'hA5C3; pats[2] = 16'h5A3C;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_full && !rx_ovf && !rx_irq && !tx_irq && !sdata_oe && rx_rdata == 0,
            "R3 reset state", rx_rdata, 0);

        // R1 all lengths, R2/R3/R5 framing, irqs, drive enable
        for (int wl = 3; wl <= 16; wl++) begin
            for (int p = 0; p < 3; p++) begin
                logic [15:0] m;
                m = 16'((32'd1 << wl) - 1);
                word_len = 4'(wl - 1);
                write_tx(~pats[p]);
                one_word(wl, pats[p]);
                chk(rx_rdata == (pats[p] & m), "R1 rx justified", rx_rdata, pats[p] & m);
                chk(txcap == ((~pats[p]) & m), "R1 tx msb first", txcap, (~pats[p]) & m);
                chk(rx_irq && tx_irq && rx_full, "R3 done pulses", {rx_irq, tx_irq}, 3);
                chk(oe_low == 0, "R5 drive during word", oe_low, 0);
                @(negedge clk);
                chk(!rx_irq && !tx_irq && !sdata_oe, "R2 single word frame", {rx_irq, sdata_oe}, 0);
                read_rx();
                chk(!rx_full, "R3 read clears", int'(rx_full), 0);
            end
        end
        // R1 floor
        word_len = 4'd0;
        one_word(3, 16'h0005);
        chk(rx_rdata == 16'h0005, "R1 minimum length", rx_rdata, 5);
        read_rx();

        // R4 overflow
        word_len = 4'd7;
        one_word(8, 16'h0011);
        chk(rx_full && !rx_ovf, "R4 first word", int'(rx_ovf), 0);
        one_word(8, 16'h0022);
        chk(rx_ovf && rx_rdata == 16'h0022, "R4 overflow keeps newest", rx_rdata, 16'h22);
        read_rx();
        chk(!rx_ovf && !rx_full, "R4 read clears overflow", int'(rx_ovf), 0);

        // R7 / R8 expansion over every code
        for (int law = 0; law < 2; law++) begin
            comp_sel = law ? CMP_A : CMP_MU;
            word_len = 4'd15;
            for (int c = 0; c < 256; c++) begin
                exp = law ? b_a_dec(c) : b_mu_dec(c);
                one_word(8, 16'(c));
                chk(rx_rdata == 16'(exp), law ? "R8 A-law expand" : "R7 mu-law expand", rx_rdata, exp & 16'hFFFF);
                read_rx();
            end
            for (int k = 0; k < 256; k++) begin
                int x;
                x = -32768 + k * 257;
                exp = law ? b_a_enc(x) : b_mu_enc(x);
                write_tx(16'(x));
                one_word(8, 16'h0000);
                chk(txcap == 16'(exp), law ? "R8 A-law compress" : "R7 mu-law compress", txcap, exp);
                read_rx();
            end
        end
        comp_sel = 2'b00;

        // R6 multichannel, 24 slots then 32 slots
        mc_en = 1'b1;
        for (int s = 0; s < 33; s++) begin
            rxv[s] = 16'((s * 5 + 3) & 15);
            txv[s] = 16'((s * 7 + 1) & 15);
        end
        word_len = 4'd3;
        mc_32 = 1'b0; rx_mask = 32'h00A5_3CF1; tx_mask = 32'h005A_C30E;
        mc_frame(24, 4);
        mc_32 = 1'b1; rx_mask = 32'hAAAA_5555; tx_mask = 32'h8555_AAAB;
        mc_frame(32, 4);
        mc_en = 1'b0;

        // R9 / R10 circular addressing
        word_len = 4'd7;
        ab_base = 12'd8; ab_len = 12'd5; ab_stride = 12'd2;
        @(negedge clk); ab_en = 1'b1;
        @(negedge clk);
        chk(rx_ab_addr == 12'd8 && tx_ab_addr == 12'd8, "R9 start at base", rx_ab_addr, 8);
        idx = 8;
        for (int w = 0; w < 7; w++) begin
            nxt = idx + 2;
            wrapped = (nxt >= 13) ? 1 : 0;
            idx = wrapped ? 8 : nxt;
            one_word(8, 16'(w));
            chk(rx_ab_addr == AW'(idx), "R9 rx address step", rx_ab_addr, idx);
            chk(tx_ab_addr == AW'(idx), "R9 tx address step", tx_ab_addr, idx);
            chk(rx_irq == wrapped[0] && tx_irq == wrapped[0], "R10 irq only at wrap", {rx_irq, tx_irq}, wrapped * 3);
            read_rx();
        end
        ab_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(rx_ab_addr == 12'd8, "R9 idle holds base", rx_ab_addr, 8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule